// File: doc/BRIEF.md
# DMA Request/Acknowledge Handshake Sequencer

This block runs the peripheral side of a single-word DMA handshake. A peripheral raises a request pin. After a programmable number of internal timing ticks, the sequencer drives an acknowledge pin. One tick later it drives a read or write strobe. When the strobe width has elapsed, acknowledge and strobe drop together and a one-cycle transfer pulse goes to the FIFO that sits beside the block. That pulse tells the FIFO to pop or push exactly one word. While the request stays active, the next word follows at the next timing tick without a second latency period.

The timing tick is either every clock or every second clock. The strobes come in one of two bus styles. One uses separate read and write strobes. The other uses a read/write level plus a data strobe. The request and acknowledge pins each have a programmable active level. An acknowledge is never issued while the FIFO that would be read is empty, or while the FIFO that would be written is full. The whole sequencer is idle unless the peripheral-mode enable is high.

No data passes through this block, so it has no valid/ready stream. Every pin is a plain control level. The transfer pulse is a strobe with no back-pressure: the adjacent FIFO must accept it in the cycle it appears. Back-pressure reaches the sequencer only through the empty and full levels, which are sampled before each acknowledge.

Top module: `dma_hs_seq`

## Requirements
- R1: After reset, the outputs are idle: the acknowledge pin is at its inactive level, rd_o, wr_o, ds_o and xfer_o are 0, and rw_o is 1.
- R2: Call the clock edge that first samples an active request E0. The acknowledge becomes active after timing tick E0+N, where N = cfg_delay_code + 2, so N is 2, 3, 4 or 5.
- R3: When cfg_half_clk is 0, the timing tick comes on every clock edge. When it is 1, the tick comes on every second edge, starting with the second edge after reset is released. Every delay, strobe width and gap is counted in ticks.
- R4: The strobe rises one tick after the acknowledge. It stays high for 1 tick when cfg_wide_strobe is 0 and for 2 ticks when it is 1. The acknowledge and the strobe fall on the same edge.
- R5: With cfg_bus_sel = 0, the strobe appears on rd_o when dir_rd = 1 and on wr_o when dir_rd = 0. In this mode ds_o stays 0 and rw_o stays 1.
- R6: With cfg_bus_sel = 1, the strobe appears on ds_o and rd_o/wr_o stay 0. rw_o shows the latched direction (1 = read, 0 = write) for the whole time the acknowledge is active, and is 1 otherwise.
- R7: The request counts as active when req_pin equals cfg_req_high. The acknowledge pin is driven to cfg_ack_high while the acknowledge is active and to its inverse otherwise.
- R8: After a transfer ends, the acknowledge stays inactive for exactly one tick. At that tick, if the request is still active, the acknowledge is re-issued without a new latency period. If the request is inactive, the sequencer returns to idle.
- R9: The acknowledge is issued only at a tick where dir_rd = 1 and out_empty = 0, or where dir_rd = 0 and in_full = 0. Until then the sequencer waits. For a read, in_full is ignored; for a write, out_empty is ignored.
- R10: xfer_o is high for exactly one clock, in the first clock after the strobe falls, once per transfer.
- R11: If the request is inactive at a tick during the latency period, the sequencer returns to idle and no acknowledge is issued.
- R12: While periph_en is 0, the sequencer is held idle. A transfer in progress is abandoned, with no xfer_o, from the clock after periph_en is sampled low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| periph_en | input | 1 | Peripheral DMA mode enable |
| cfg_half_clk | input | 1 | 1: timing tick every second clock |
| cfg_wide_strobe | input | 1 | 1: strobe lasts 2 ticks |
| cfg_delay_code | input | 2 | Request-to-acknowledge delay, code + 2 ticks |
| cfg_req_high | input | 1 | Active level of req_pin |
| cfg_ack_high | input | 1 | Active level of ack_pin |
| cfg_bus_sel | input | 1 | 0: separate read/write strobes, 1: R/W level plus data strobe |
| req_pin | input | 1 | Peripheral request |
| dir_rd | input | 1 | 1: peripheral reads (outbound FIFO pops), 0: peripheral writes |
| out_empty | input | 1 | Outbound FIFO is empty |
| in_full | input | 1 | Inbound FIFO is full |
| ack_pin | output | 1 | Acknowledge, at the programmed level |
| rd_o | output | 1 | Read strobe, separate-strobe style |
| wr_o | output | 1 | Write strobe, separate-strobe style |
| ds_o | output | 1 | Data strobe, combined style |
| rw_o | output | 1 | Read/write level, combined style |
| xfer_o | output | 1 | One-cycle pop/push pulse to the FIFO |

## Verification
The bench sweeps every combination of tick rate, strobe width, delay code, bus style, direction and both pin polarities. In each run it compares all outputs cycle by cycle against a timeline computed from tick arithmetic. An off-by-one in the latency counter, or a half-rate tick with the wrong phase, shifts the acknowledge edge and is caught. So is a design that repeats the full latency on back-to-back words: it opens a gap longer than one tick. Separate runs hold the empty or full level on the relevant side, where a design that tests the wrong flag acknowledges too early or never. Further runs drop the request in mid-latency, where a faulty design still issues an acknowledge, and pull the enable low in mid-strobe, where a faulty design keeps driving the strobe or still emits a transfer pulse.

// File: rtl/dma_hs_pkg.sv
package dma_hs_pkg;

  typedef enum logic [2:0] {
    HS_IDLE  = 3'd0,
    HS_DELAY = 3'd1,
    HS_ACK   = 3'd2,
    HS_STRB  = 3'd3,
    HS_GAP   = 3'd4
  } hs_state_e;

  typedef enum logic {
    BUS_SPLIT = 1'b0,
    BUS_RWDS  = 1'b1
  } bus_style_e;

endpackage

// File: rtl/dma_hs_tick.sv
module dma_hs_tick #(
  parameter int SLOW_DIV = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic slow,
  output logic tick
);
  generate
    if (SLOW_DIV > 1) begin : g_div
      localparam int PH_W = $clog2(SLOW_DIV);
      localparam logic [PH_W-1:0] PH_LAST = PH_W'(SLOW_DIV - 1);
      logic [PH_W-1:0] ph_q;

      always_ff @(posedge clk) begin
        if (rst) begin
          ph_q <= '0;
        end else if (ph_q == PH_LAST) begin
          ph_q <= '0;
        end else begin
          ph_q <= ph_q + 1'b1;
        end
      end

      assign tick = !slow || (ph_q == PH_LAST);
    end else begin : g_nodiv
      logic unused_ok;
      assign unused_ok = slow ^ rst ^ clk;
      assign tick = 1'b1;
    end
  endgenerate
endmodule

// File: rtl/dma_hs_fsm.sv
module dma_hs_fsm
  import dma_hs_pkg::*;
#(
  parameter int DELAY_BASE  = 2,
  parameter int CODE_W      = 2,
  parameter int WIDE_TICKS  = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              en,
  input  logic              tick,
  input  logic              req_act,
  input  logic [CODE_W-1:0] delay_code,
  input  logic              wide,
  input  logic              dir_rd,
  input  logic              out_empty,
  input  logic              in_full,
  output hs_state_e         state,
  output logic              dir_lat,
  output logic              xfer
);
  localparam int DLY_MAX = DELAY_BASE + (1 << CODE_W) - 1;
  localparam int CNT_W   = $clog2(DLY_MAX + 1);
  localparam int W_W     = (WIDE_TICKS > 1) ? $clog2(WIDE_TICKS) : 1;

  hs_state_e        state_q, state_n;
  logic [CNT_W-1:0] cnt_q, cnt_n;
  logic [W_W-1:0]   wcnt_q, wcnt_n;
  logic             dir_q, dir_n;
  logic             xfer_q, xfer_n;

  logic [CNT_W-1:0] dly_last;
  logic [W_W-1:0]   wid_last;
  logic             side_ok;

  assign dly_last = CNT_W'(DELAY_BASE) + CNT_W'(delay_code) - 1'b1;
  assign wid_last = wide ? W_W'(WIDE_TICKS - 1) : '0;
  assign side_ok  = dir_rd ? !out_empty : !in_full;

  always_comb begin
    state_n = state_q;
    cnt_n   = cnt_q;
    wcnt_n  = wcnt_q;
    dir_n   = dir_q;
    xfer_n  = 1'b0;
    if (!en) begin
      state_n = HS_IDLE;
      cnt_n   = '0;
      wcnt_n  = '0;
    end else if (tick) begin
      unique case (state_q)
        HS_IDLE: begin
          if (req_act) begin
            state_n = HS_DELAY;
            cnt_n   = '0;
          end
        end
        HS_DELAY: begin
          if (!req_act) begin
            state_n = HS_IDLE;
          end else if (cnt_q >= dly_last) begin
            if (side_ok) begin
              state_n = HS_ACK;
              dir_n   = dir_rd;
            end
          end else begin
            cnt_n = cnt_q + 1'b1;
          end
        end
        HS_ACK: begin
          state_n = HS_STRB;
          wcnt_n  = '0;
        end
        HS_STRB: begin
          if (wcnt_q >= wid_last) begin
            state_n = HS_GAP;
            xfer_n  = 1'b1;
          end else begin
            wcnt_n = wcnt_q + 1'b1;
          end
        end
        HS_GAP: begin
          if (!req_act) begin
            state_n = HS_IDLE;
          end else if (side_ok) begin
            state_n = HS_ACK;
            dir_n   = dir_rd;
          end
        end
        default: state_n = HS_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= HS_IDLE;
      cnt_q   <= '0;
      wcnt_q  <= '0;
      dir_q   <= 1'b1;
      xfer_q  <= 1'b0;
    end else begin
      state_q <= state_n;
      cnt_q   <= cnt_n;
      wcnt_q  <= wcnt_n;
      dir_q   <= dir_n;
      xfer_q  <= xfer_n;
    end
  end

  assign state   = state_q;
  assign dir_lat = dir_q;
  assign xfer    = xfer_q;
endmodule

// File: rtl/dma_hs_pins.sv
module dma_hs_pins
  import dma_hs_pkg::*;
(
  input  hs_state_e  state,
  input  logic       dir_lat,
  input  bus_style_e style,
  input  logic       ack_high,
  output logic       ack_pin,
  output logic       rd_o,
  output logic       wr_o,
  output logic       ds_o,
  output logic       rw_o
);
  logic ack_act, strobe;

  assign ack_act = (state == HS_ACK) || (state == HS_STRB);
  assign strobe  = (state == HS_STRB);

  assign ack_pin = ack_high ? ack_act : !ack_act;

  always_comb begin
    rd_o = 1'b0;
    wr_o = 1'b0;
    ds_o = 1'b0;
    rw_o = 1'b1;
    if (style == BUS_SPLIT) begin
      rd_o = strobe && dir_lat;
      wr_o = strobe && !dir_lat;
    end else begin
      ds_o = strobe;
      if (ack_act) rw_o = dir_lat;
    end
  end
endmodule

// File: rtl/dma_hs_seq.sv
module dma_hs_seq
  import dma_hs_pkg::*;
#(
  parameter int SLOW_DIV   = 2,
  parameter int DELAY_BASE = 2,
  parameter int CODE_W     = 2,
  parameter int WIDE_TICKS = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              periph_en,
  input  logic              cfg_half_clk,
  input  logic              cfg_wide_strobe,
  input  logic [CODE_W-1:0] cfg_delay_code,
  input  logic              cfg_req_high,
  input  logic              cfg_ack_high,
  input  logic              cfg_bus_sel,
  input  logic              req_pin,
  input  logic              dir_rd,
  input  logic              out_empty,
  input  logic              in_full,
  output logic              ack_pin,
  output logic              rd_o,
  output logic              wr_o,
  output logic              ds_o,
  output logic              rw_o,
  output logic              xfer_o
);
  logic      tick, req_act, dir_lat;
  hs_state_e state;

  assign req_act = (req_pin == cfg_req_high);

  dma_hs_tick #(.SLOW_DIV(SLOW_DIV)) u_tick (
    .clk  (clk),
    .rst  (rst),
    .slow (cfg_half_clk),
    .tick (tick)
  );

  dma_hs_fsm #(
    .DELAY_BASE (DELAY_BASE),
    .CODE_W     (CODE_W),
    .WIDE_TICKS (WIDE_TICKS)
  ) u_fsm (
    .clk        (clk),
    .rst        (rst),
    .en         (periph_en),
    .tick       (tick),
    .req_act    (req_act),
    .delay_code (cfg_delay_code),
    .wide       (cfg_wide_strobe),
    .dir_rd     (dir_rd),
    .out_empty  (out_empty),
    .in_full    (in_full),
    .state      (state),
    .dir_lat    (dir_lat),
    .xfer       (xfer_o)
  );

  dma_hs_pins u_pins (
    .state    (state),
    .dir_lat  (dir_lat),
    .style    (bus_style_e'(cfg_bus_sel)),
    .ack_high (cfg_ack_high),
    .ack_pin  (ack_pin),
    .rd_o     (rd_o),
    .wr_o     (wr_o),
    .ds_o     (ds_o),
    .rw_o     (rw_o)
  );
endmodule

// File: rtl/dma_hs_chk.sv
module dma_hs_chk (
  input logic clk,
  input logic rst,
  input logic periph_en,
  input logic cfg_ack_high,
  input logic dir_rd,
  input logic out_empty,
  input logic in_full,
  input logic ack_pin,
  input logic rd_o,
  input logic wr_o,
  input logic ds_o,
  input logic rw_o,
  input logic xfer_o
);
  logic ack_on, strb_on, side_ok;
  assign ack_on  = (ack_pin == cfg_ack_high);
  assign strb_on = rd_o || wr_o || ds_o;
  assign side_ok = dir_rd ? !out_empty : !in_full;

  // R4
  ack_covers_strobe_chk: assert property (@(posedge clk) disable iff (rst)
    strb_on |-> ack_on);

  // R5
  rd_wr_excl_chk: assert property (@(posedge clk) disable iff (rst)
    !(rd_o && wr_o));

  // R10
  xfer_one_cycle_chk: assert property (@(posedge clk) disable iff (rst)
    xfer_o |=> !xfer_o);

  // R10
  xfer_after_strobe_chk: assert property (@(posedge clk) disable iff (rst)
    xfer_o |-> ($past(strb_on) && !strb_on && !ack_on));

  // R9
  ack_needs_room_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(ack_on) |-> $past(side_ok));

  // R6
  rw_steady_chk: assert property (@(posedge clk) disable iff (rst)
    (ack_on && $past(ack_on)) |-> $stable(rw_o));

  // R12
  en_off_idle_chk: assert property (@(posedge clk) disable iff (rst)
    !periph_en |=> (!ack_on && !strb_on && !xfer_o));
endmodule

bind dma_hs_seq dma_hs_chk u_chk (
  .clk          (clk),
  .rst          (rst),
  .periph_en    (periph_en),
  .cfg_ack_high (cfg_ack_high),
  .dir_rd       (dir_rd),
  .out_empty    (out_empty),
  .in_full      (in_full),
  .ack_pin      (ack_pin),
  .rd_o         (rd_o),
  .wr_o         (wr_o),
  .ds_o         (ds_o),
  .rw_o         (rw_o),
  .xfer_o       (xfer_o)
);

// File: tb/dma_hs_seq_test.sv
module dma_hs_seq_test;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic periph_en = 1'b1;
  logic cfg_half_clk = 1'b0, cfg_wide_strobe = 1'b0;
  logic [1:0] cfg_delay_code = 2'd0;
  logic cfg_req_high = 1'b1, cfg_ack_high = 1'b1, cfg_bus_sel = 1'b0;
  logic req_pin = 1'b0, dir_rd = 1'b1, out_empty = 1'b0, in_full = 1'b0;
  logic ack_pin, rd_o, wr_o, ds_o, rw_o, xfer_o;

  int checks = 0;
  int fails = 0;
  int cyc = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  dma_hs_seq uut (
    .clk(clk), .rst(rst), .periph_en(periph_en),
    .cfg_half_clk(cfg_half_clk), .cfg_wide_strobe(cfg_wide_strobe),
    .cfg_delay_code(cfg_delay_code), .cfg_req_high(cfg_req_high),
    .cfg_ack_high(cfg_ack_high), .cfg_bus_sel(cfg_bus_sel),
    .req_pin(req_pin), .dir_rd(dir_rd), .out_empty(out_empty),
    .in_full(in_full), .ack_pin(ack_pin), .rd_o(rd_o), .wr_o(wr_o),
    .ds_o(ds_o), .rw_o(rw_o), .xfer_o(xfer_o)
  );

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > 150000 && !done) begin
      fails++;
      $display("FAIL watchdog actual=%0d expected<=150000", cyc);
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  task automatic chk(input string tag, input logic [5:0] act, input logic [5:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s t=%0t actual=%b expected=%b (ack rd wr ds rw xfer)", tag, $time, act, exp);
    end
  endtask

  function automatic logic [5:0] outs();
    return {ack_pin, rd_o, wr_o, ds_o, rw_o, xfer_o};
  endfunction

  function automatic logic [5:0] idle_vec(input logic ap);
    return {!ap, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0};
  endfunction

  // reset, release at a negedge, then wait three edges (next edge is a tick in both rates)
  task automatic do_reset();
    rst = 1'b1;
    req_pin = !cfg_req_high;
    repeat (2) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    repeat (3) @(negedge clk);
    chk("R1 idle after reset", outs(), idle_vec(cfg_ack_high));
  endtask

  task automatic set_cfg(input logic half, wide, input logic [1:0] code,
                         input logic bus, dir, rp, ap);
    cfg_half_clk = half; cfg_wide_strobe = wide; cfg_delay_code = code;
    cfg_bus_sel = bus; dir_rd = dir; cfg_req_high = rp; cfg_ack_high = ap;
  endtask

  task automatic sweep_one();
    int p, w, d, a1, s1, a2, s2;
    p  = cfg_half_clk ? 2 : 1;
    w  = cfg_wide_strobe ? 2 : 1;
    d  = int'(cfg_delay_code) + 2;
    a1 = 1 + p * d;
    s1 = a1 + p + p * w;
    a2 = s1 + p;
    s2 = a2 + p + p * w;
    req_pin = cfg_req_high;
    for (int c = 1; c <= s2 + 4; c++) begin
      logic ak, st, xf;
      logic [5:0] e;
      @(negedge clk);
      ak = (c >= a1 && c < s1) || (c >= a2 && c < s2);
      st = (c >= a1 + p && c < s1) || (c >= a2 + p && c < s2);
      xf = (c == s1) || (c == s2);
      e = {cfg_ack_high ? ak : !ak,
           st && !cfg_bus_sel && dir_rd,
           st && !cfg_bus_sel && !dir_rd,
           st && cfg_bus_sel,
           (cfg_bus_sel && ak) ? dir_rd : 1'b1,
           xf};
      chk("R2 R3 R4 R5 R6 R7 R8 R10 timeline", outs(), e);
      if (c == a2) req_pin = !cfg_req_high;
    end
  endtask

  initial begin
    // exhaustive sweep over tick rate, width, delay, style, direction, polarities
    for (int k = 0; k < 256; k++) begin
      logic [7:0] v;
      v = 8'(k);
      set_cfg(v[0], v[1], v[3:2], v[4], v[5], v[6], v[7]);
      do_reset();
      sweep_one();
    end

    // R9: read held off by empty outbound side, in_full ignored
    set_cfg(1'b0, 1'b0, 2'd0, 1'b0, 1'b1, 1'b1, 1'b1);
    out_empty = 1'b1; in_full = 1'b1;
    do_reset();
    req_pin = 1'b1;
    for (int c = 1; c <= 9; c++) begin
      @(negedge clk);
      if (c <= 8) chk("R9 read withheld while empty", outs(), idle_vec(1'b1));
      else        chk("R9 read ack after empty clears", outs(), 6'b100010);
      if (c == 8) out_empty = 1'b0;
    end
    req_pin = 1'b0;
    repeat (6) @(negedge clk);

    // R9: write held off by full inbound side, out_empty ignored
    set_cfg(1'b0, 1'b0, 2'd0, 1'b0, 1'b0, 1'b1, 1'b1);
    out_empty = 1'b1; in_full = 1'b1;
    do_reset();
    req_pin = 1'b1;
    for (int c = 1; c <= 10; c++) begin
      @(negedge clk);
      if (c <= 8)       chk("R9 write withheld while full", outs(), idle_vec(1'b1));
      else if (c == 9)  chk("R9 write ack after full clears", outs(), 6'b100010);
      else              chk("R9 write strobe follows", outs(), 6'b101010);
      if (c == 8) in_full = 1'b0;
    end
    req_pin = 1'b0; out_empty = 1'b0;
    repeat (6) @(negedge clk);

    // R11: request dropped during latency aborts the transfer
    set_cfg(1'b0, 1'b0, 2'd3, 1'b0, 1'b1, 1'b1, 1'b1);
    do_reset();
    req_pin = 1'b1;
    for (int c = 1; c <= 12; c++) begin
      @(negedge clk);
      chk("R11 no ack after aborted request", outs(), idle_vec(1'b1));
      if (c == 2) req_pin = 1'b0;
    end

    // R12: enable low keeps idle even with request active
    set_cfg(1'b0, 1'b0, 2'd0, 1'b1, 1'b1, 1'b1, 1'b1);
    do_reset();
    periph_en = 1'b0;
    req_pin = 1'b1;
    for (int c = 1; c <= 10; c++) begin
      @(negedge clk);
      chk("R12 idle while disabled", outs(), idle_vec(1'b1));
    end
    req_pin = 1'b0;
    periph_en = 1'b1;
    repeat (3) @(negedge clk);

    // R12: enable dropped during strobe abandons transfer, no xfer pulse
    set_cfg(1'b0, 1'b1, 2'd0, 1'b0, 1'b1, 1'b1, 1'b1);
    do_reset();
    req_pin = 1'b1;
    for (int c = 1; c <= 10; c++) begin
      @(negedge clk);
      if (c == 4) begin
        chk("R12 strobe up before disable", outs(), 6'b110010);
        periph_en = 1'b0;
      end else if (c > 4) begin
        chk("R12 abandoned after disable", outs(), idle_vec(1'b1));
      end
    end
    req_pin = 1'b0;
    periph_en = 1'b1;

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule